// File: doc/BRIEF.md
# Nested Trap Level Controller

This block handles trap entry and trap return for a core that allows traps to nest. It keeps a trap level counter and one stack slot per level. On an accepted trap it stores the pre-trap program counter pair, the trap type and a packed state word in the slot for the current level. It then issues a one-cycle redirect that carries the vector address, the entry processor-state bits and the new window pointer, and raises the level.

A return instruction reads the slot one below the current level. The retry form resumes at the saved PC. The done form resumes at the saved next PC. Both forms hand back the saved condition codes, address-space identifier, processor state and window pointer, and lower the level. Register-window contents, instruction fetch and the producers of the condition codes lie outside the block. It receives their current values as inputs and returns the values to load as outputs.

The window count `NWIN` must be a power of two, and `NWIN` must not exceed 256. `MAXTL` sets the deepest level.

Top module: `trap_level_ctrl`

## Requirements
- R1: After reset, `tl_o`, `redirect_o`, `error_o`, `pc_o`, `npc_o`, `pstate_o`, `top_tt_o` and `top_state_o` are all zero.
- R2: An accepted trap causes the following on the next clock edge. `redirect_o` pulses for one cycle. `pc_o` becomes `{tba_i, nested, trap_type_i, 5'b0}`, where `nested` is 1 when the pre-trap level is above 1. `npc_o` becomes `pc_o + 4`. `ccr_o` and `asi_o` take `ccr_i` and `asi_i`.
- R3: On an accepted trap, `pstate_o` becomes 12'h015, which sets bit 4 (FP enable), bit 2 (privileged) and bit 0 (alternate globals). Bit 5 (error recovery, value 12'h020) is also set when the pre-trap level equals `MAXTL-1`.
- R4: An accepted trap raises `tl_o` by one. `tl_o` never exceeds `MAXTL`.
- R5: On an accepted trap, `cwp_o` is set as follows, with all arithmetic modulo `NWIN`:
  - type 9'h024: `cwp_i-1`;
  - type bits [8:6] = 3'b010: `cwp_i-cansave_i-2`;
  - type bits [8:6] = 3'b011: `cwp_i+1`;
  - any other type: `cwp_i`.
- R6: A retry return (`retry_i`=1) gives `pc_o` = the saved PC and `npc_o` = the saved next PC of level `tl_o-1`.
- R7: A done return (`retry_i`=0) gives `pc_o` = the saved next PC and `npc_o` = the saved next PC + 4.
- R8: Any accepted return restores `ccr_o`, `asi_o`, `cwp_o` and `pstate_o` from the saved slot. The restored `pstate_o` is the pre-trap state masked with 12'hF3F. An accepted return also lowers `tl_o` by one.
- R9: A trap that arrives while `tl_o` equals `MAXTL` saves nothing and causes no redirect. It leaves `tl_o` unchanged and sets `error_o`, which stays set until reset.
- R10: When `trap_i` and `ret_i` are high in the same cycle, only the trap takes effect.
- R11: A return while `tl_o` is 0 has no effect: there is no redirect, and the level and outputs are unchanged.
- R12: When `tl_o` is above 0, `top_tt_o` and `top_state_o` show the innermost saved trap type and state word. When `tl_o` is 0, both are 0. The state word is laid out as follows:
  - bits [39:32]: condition codes;
  - bits [31:24]: address-space identifier;
  - bits [23:20]: zero;
  - bits [19:8]: pstate masked with 12'hF3F;
  - bits [7:0]: zero-extended window pointer.
- R13: In a cycle with no accepted trap or return, `redirect_o` is low and `pc_o`, `npc_o`, `ccr_o`, `asi_o`, `pstate_o` and `cwp_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Trap request, one cycle |
| trap_type_i | input | 9 | Trap type |
| ret_i | input | 1 | Trap return request, one cycle |
| retry_i | input | 1 | Return form: 1 resumes at saved PC, 0 at saved next PC |
| pc_i | input | PC_W | Current PC |
| npc_i | input | PC_W | Current next PC |
| ccr_i | input | 8 | Current condition codes |
| asi_i | input | 8 | Current address-space identifier |
| pstate_i | input | 12 | Current processor state |
| cwp_i | input | $clog2(NWIN) | Current window pointer |
| cansave_i | input | $clog2(NWIN) | Windows free to save |
| tba_i | input | PC_W-15 | Trap base address, upper bits |
| redirect_o | output | 1 | New PC/state valid this cycle |
| pc_o | output | PC_W | New PC |
| npc_o | output | PC_W | New next PC |
| ccr_o | output | 8 | Condition codes to load |
| asi_o | output | 8 | Address-space identifier to load |
| pstate_o | output | 12 | Processor state to load |
| cwp_o | output | $clog2(NWIN) | Window pointer to load |
| tl_o | output | $clog2(MAXTL+1) | Current trap level |
| top_tt_o | output | 9 | Innermost saved trap type |
| top_state_o | output | 40 | Innermost saved state word |
| error_o | output | 1 | Trap taken at the deepest level (sticky) |

## Verification
The assertions assume the following about the inputs:
- `trap_i` and `ret_i` are single-cycle requests that the core issues only when it can accept a redirect.
- `cansave_i` and `cwp_i` lie within the window count.
- `tba_i` stays stable while traps are taken.

The stimulus pulses each request for one clock and drives every field within its declared width. It walks the level from 0 up to `MAXTL`, then fires one trap beyond the top and unwinds every level back below 0. Along the way it also issues a return and a trap together in one cycle.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;
  localparam int TT_W    = 9;
  localparam int CCR_W   = 8;
  localparam int ASI_W   = 8;
  localparam int PST_W   = 12;
  localparam int STATE_W = 40;

  localparam logic [PST_W-1:0] PST_KEEP_MASK = 12'hF3F;
  localparam logic [PST_W-1:0] PST_ON_ENTRY  = 12'h015;  // fp enable, priv, alt globals
  localparam logic [PST_W-1:0] PST_ERR_RECOV = 12'h020;

  localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
  localparam logic [2:0]      TT_GRP_SPILL = 3'b010;
  localparam logic [2:0]      TT_GRP_FILL  = 3'b011;

  typedef struct packed {
    logic [CCR_W-1:0] ccr;
    logic [ASI_W-1:0] asi;
    logic [3:0]       zero;
    logic [PST_W-1:0] pst;
    logic [7:0]       cwp;
  } tstate_t;
endpackage

// File: rtl/trap_slot_file.sv
module trap_slot_file #(
  parameter int DEPTH = 5,
  parameter int W     = 32,
  parameter int AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               slot_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))        slot_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (raddr_i == AW'(i)) rdata_o = slot_q[i];
  end
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc
  import trap_ctrl_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int CWP_W = 3
) (
  input  logic [PC_W-16:0]  tba_i,
  input  logic [TT_W-1:0]   tt_i,
  input  logic              nested_i,
  input  logic              near_top_i,
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [CWP_W-1:0]  cansave_i,
  output logic [PC_W-1:0]   vec_pc_o,
  output logic [PST_W-1:0]  pstate_o,
  output logic [CWP_W-1:0]  cwp_o
);
  assign vec_pc_o = {tba_i, nested_i, tt_i, 5'b0};
  assign pstate_o = PST_ON_ENTRY | (near_top_i ? PST_ERR_RECOV : '0);

  always_comb begin
    if (tt_i == TT_CLEAN_WIN)              cwp_o = cwp_i - CWP_W'(1);
    else if (tt_i[8:6] == TT_GRP_SPILL)    cwp_o = cwp_i - cansave_i - CWP_W'(2);
    else if (tt_i[8:6] == TT_GRP_FILL)     cwp_o = cwp_i + CWP_W'(1);
    else                                   cwp_o = cwp_i;
  end
endmodule

// File: rtl/trap_level_ctrl.sv
module trap_level_ctrl
  import trap_ctrl_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int NWIN  = 8,
  parameter int MAXTL = 5,
  localparam int CWP_W = $clog2(NWIN),
  localparam int TL_W  = $clog2(MAXTL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_i,
  input  logic [TT_W-1:0]   trap_type_i,
  input  logic              ret_i,
  input  logic              retry_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   npc_i,
  input  logic [CCR_W-1:0]  ccr_i,
  input  logic [ASI_W-1:0]  asi_i,
  input  logic [PST_W-1:0]  pstate_i,
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [CWP_W-1:0]  cansave_i,
  input  logic [PC_W-16:0]  tba_i,
  output logic              redirect_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   npc_o,
  output logic [CCR_W-1:0]  ccr_o,
  output logic [ASI_W-1:0]  asi_o,
  output logic [PST_W-1:0]  pstate_o,
  output logic [CWP_W-1:0]  cwp_o,
  output logic [TL_W-1:0]   tl_o,
  output logic [TT_W-1:0]   top_tt_o,
  output logic [STATE_W-1:0] top_state_o,
  output logic              error_o
);
  localparam int REC_W = TT_W + 2 * PC_W + STATE_W;
  localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAXTL);

  logic [TL_W-1:0]  tl_q;
  logic             err_q, redir_q;
  logic [PC_W-1:0]  pc_q, npc_q;
  logic [CCR_W-1:0] ccr_q;
  logic [ASI_W-1:0] asi_q;
  logic [PST_W-1:0] pst_q;
  logic [CWP_W-1:0] cwp_q;

  logic trap_ok, ret_ok;
  assign trap_ok = trap_i && (tl_q != TL_TOP);
  assign ret_ok  = ret_i && !trap_i && (tl_q != '0);

  tstate_t save_st, rd_st;
  always_comb begin
    save_st      = '0;
    save_st.ccr  = ccr_i;
    save_st.asi  = asi_i;
    save_st.pst  = pstate_i & PST_KEEP_MASK;
    save_st.cwp  = 8'(cwp_i);
  end

  logic [REC_W-1:0] rd_rec;
  logic [TT_W-1:0]  rd_tt;
  logic [PC_W-1:0]  rd_pc, rd_npc;
  logic [TL_W-1:0]  rd_idx;
  assign rd_idx = tl_q - TL_W'(1);

  trap_slot_file #(.DEPTH(MAXTL), .W(REC_W), .AW(TL_W)) u_slots (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (trap_ok),
    .waddr_i (tl_q),
    .wdata_i ({trap_type_i, pc_i, npc_i, save_st}),
    .raddr_i (rd_idx),
    .rdata_o (rd_rec)
  );
  assign {rd_tt, rd_pc, rd_npc, rd_st} = rd_rec;

  logic [PC_W-1:0]  vec_pc;
  logic [PST_W-1:0] vec_pst;
  logic [CWP_W-1:0] vec_cwp;

  trap_vec_calc #(.PC_W(PC_W), .CWP_W(CWP_W)) u_vec (
    .tba_i      (tba_i),
    .tt_i       (trap_type_i),
    .nested_i   (tl_q > TL_W'(1)),
    .near_top_i (tl_q >= TL_W'(MAXTL - 1)),
    .cwp_i      (cwp_i),
    .cansave_i  (cansave_i),
    .vec_pc_o   (vec_pc),
    .pstate_o   (vec_pst),
    .cwp_o      (vec_cwp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tl_q <= '0; err_q <= 1'b0; redir_q <= 1'b0;
      pc_q <= '0; npc_q <= '0; ccr_q <= '0; asi_q <= '0;
      pst_q <= '0; cwp_q <= '0;
    end else if (trap_i) begin
      if (trap_ok) begin
        redir_q <= 1'b1;
        pc_q    <= vec_pc;
        npc_q   <= vec_pc + PC_W'(4);
        ccr_q   <= ccr_i;
        asi_q   <= asi_i;
        pst_q   <= vec_pst;
        cwp_q   <= vec_cwp;
        tl_q    <= tl_q + TL_W'(1);
      end else begin
        redir_q <= 1'b0;
        err_q   <= 1'b1;
      end
    end else if (ret_ok) begin
      redir_q <= 1'b1;
      pc_q    <= retry_i ? rd_pc : rd_npc;
      npc_q   <= retry_i ? rd_npc : rd_npc + PC_W'(4);
      ccr_q   <= rd_st.ccr;
      asi_q   <= rd_st.asi;
      pst_q   <= rd_st.pst;
      cwp_q   <= rd_st.cwp[CWP_W-1:0];
      tl_q    <= tl_q - TL_W'(1);
    end else begin
      redir_q <= 1'b0;
    end
  end

  assign redirect_o  = redir_q;
  assign pc_o        = pc_q;
  assign npc_o       = npc_q;
  assign ccr_o       = ccr_q;
  assign asi_o       = asi_q;
  assign pstate_o    = pst_q;
  assign cwp_o       = cwp_q;
  assign tl_o        = tl_q;
  assign error_o     = err_q;
  assign top_tt_o    = (tl_q == '0) ? '0 : rd_tt;
  assign top_state_o = (tl_q == '0) ? '0 : rd_st;
endmodule

// File: rtl/trap_level_ctrl_chk.sv
module trap_level_ctrl_chk #(
  parameter int MAXTL = 5,
  parameter int TL_W  = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_i,
  input logic            ret_i,
  input logic [TL_W-1:0] tl_o,
  input logic            redirect_o,
  input logic            error_o,
  input logic [11:0]     pstate_o
);
  localparam logic [TL_W-1:0] TOP = TL_W'(MAXTL);

  AST_TL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tl_o <= TOP); // R4
  AST_TRAP_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && tl_o != TOP |=> redirect_o && tl_o == TL_W'($past(tl_o) + 1'b1)); // R10
  AST_TRAP_PSTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && tl_o != TOP |=> pstate_o[4] && pstate_o[2] && pstate_o[0]); // R3
  AST_TOP_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && tl_o == TOP |=> error_o && !redirect_o && $stable(tl_o)); // R9
  AST_ERROR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o); // R9
  AST_RET_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !trap_i && tl_o != '0 |=> redirect_o && tl_o == TL_W'($past(tl_o) - 1'b1)); // R8
  AST_RET_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !trap_i && tl_o == '0 |=> !redirect_o && tl_o == '0); // R11
endmodule

bind trap_level_ctrl trap_level_ctrl_chk #(.MAXTL(MAXTL), .TL_W(TL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trap_i     (trap_i),
  .ret_i      (ret_i),
  .tl_o       (tl_o),
  .redirect_o (redirect_o),
  .error_o    (error_o),
  .pstate_o   (pstate_o)
);

// File: tb/trap_level_ctrl_tb.sv
`timescale 1ns/1ps
module trap_level_ctrl_tb;
  localparam int PC_W = 64, NWIN = 8, MAXTL = 5;
  localparam logic [48:0] TBA = 49'h1ABCD;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic trap_i = 0, ret_i = 0, retry_i = 0;
  logic [8:0] trap_type_i = '0;
  logic [63:0] pc_i = '0, npc_i = '0;
  logic [7:0] ccr_i = '0, asi_i = '0;
  logic [11:0] pstate_i = '0;
  logic [2:0] cwp_i = '0, cansave_i = '0;
  logic redirect_o, error_o;
  logic [63:0] pc_o, npc_o;
  logic [7:0] ccr_o, asi_o;
  logic [11:0] pstate_o;
  logic [2:0] cwp_o, tl_o;
  logic [8:0] top_tt_o;
  logic [39:0] top_state_o;

  trap_level_ctrl #(.PC_W(PC_W), .NWIN(NWIN), .MAXTL(MAXTL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .trap_i(trap_i), .trap_type_i(trap_type_i),
    .ret_i(ret_i), .retry_i(retry_i), .pc_i(pc_i), .npc_i(npc_i),
    .ccr_i(ccr_i), .asi_i(asi_i), .pstate_i(pstate_i), .cwp_i(cwp_i),
    .cansave_i(cansave_i), .tba_i(TBA), .redirect_o(redirect_o), .pc_o(pc_o),
    .npc_o(npc_o), .ccr_o(ccr_o), .asi_o(asi_o), .pstate_o(pstate_o),
    .cwp_o(cwp_o), .tl_o(tl_o), .top_tt_o(top_tt_o), .top_state_o(top_state_o),
    .error_o(error_o));

  typedef struct packed {
    logic trap; logic ret; logic retry; logic [8:0] tt; logic [31:0] pc;
    logic [7:0] ccr; logic [7:0] asi; logic [11:0] pst; logic [2:0] cwp; logic [2:0] cs;
  } op_t;

  localparam int NOPS = 17;
  localparam op_t OPS [NOPS] = '{
    '{1'b1,1'b0,1'b0,9'h041,32'h1000,8'h5A,8'h80,12'hFFF,3'd3,3'd1}, // R5 other type keeps cwp
    '{1'b1,1'b0,1'b0,9'h024,32'h2000,8'h11,8'h22,12'h013,3'd3,3'd0}, // R5 clean window
    '{1'b1,1'b0,1'b0,9'h085,32'h3000,8'h33,8'h44,12'h0A5,3'd5,3'd2}, // R5 spill, nested bit
    '{1'b0,1'b1,1'b1,9'h000,32'h0,   8'h00,8'h00,12'h000,3'd0,3'd0}, // R6 retry
    '{1'b1,1'b0,1'b0,9'h0C3,32'h4000,8'h66,8'h77,12'h0C0,3'd7,3'd0}, // R5 fill wraps
    '{1'b0,1'b1,1'b0,9'h000,32'h0,   8'h00,8'h00,12'h000,3'd0,3'd0}, // R7 done
    '{1'b1,1'b1,1'b1,9'h060,32'h5000,8'h99,8'hAA,12'h300,3'd2,3'd0}, // R10 trap wins
    '{1'b1,1'b0,1'b0,9'h1FF,32'h6000,8'hBB,8'hCC,12'h800,3'd6,3'd0}, // R4 to MAXTL-1
    '{1'b1,1'b0,1'b0,9'h0A0,32'h7000,8'hDD,8'hEE,12'h444,3'd4,3'd1}, // R3 error-recovery bit
    '{1'b1,1'b0,1'b0,9'h001,32'h8000,8'h01,8'h02,12'h111,3'd1,3'd0}, // R9 trap at top
    '{1'b0,1'b1,1'b0,9'h000,32'h0,   8'h00,8'h00,12'h000,3'd0,3'd0},
    '{1'b0,1'b1,1'b1,9'h000,32'h0,   8'h00,8'h00,12'h000,3'd0,3'd0},
    '{1'b0,1'b1,1'b0,9'h000,32'h0,   8'h00,8'h00,12'h000,3'd0,3'd0},
    '{1'b0,1'b1,1'b1,9'h000,32'h0,   8'h00,8'h00,12'h000,3'd0,3'd0},
    '{1'b0,1'b1,1'b0,9'h000,32'h0,   8'h00,8'h00,12'h000,3'd0,3'd0},
    '{1'b0,1'b1,1'b0,9'h000,32'h0,   8'h00,8'h00,12'h000,3'd0,3'd0}, // R11 empty
    '{1'b0,1'b0,1'b0,9'h000,32'h0,   8'h00,8'h00,12'h000,3'd0,3'd0}  // R13 idle hold
  };

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model
  int e_tl = 0;
  logic e_redir = 0, e_err = 0;
  logic [63:0] e_pc = 0, e_npc = 0;
  logic [7:0] e_ccr = 0, e_asi = 0;
  logic [11:0] e_pst = 0;
  logic [2:0] e_cwp = 0;
  logic [63:0] m_pc [MAXTL], m_npc [MAXTL];
  logic [8:0] m_tt [MAXTL];
  logic [39:0] m_st [MAXTL];

  task automatic run_op(op_t o);
    string tag;
    @(negedge clk);
    trap_i = o.trap; ret_i = o.ret; retry_i = o.retry; trap_type_i = o.tt;
    pc_i = 64'(o.pc); npc_i = 64'(o.pc) + 64'd4; ccr_i = o.ccr; asi_i = o.asi;
    pstate_i = o.pst; cwp_i = o.cwp; cansave_i = o.cs;
    @(posedge clk); #1;
    trap_i = 0; ret_i = 0;
    if (o.trap && o.ret) tag = "R10";
    else if (o.trap) tag = (e_tl != MAXTL) ? "R2" : "R9";
    else if (o.ret) tag = (e_tl > 0) ? (o.retry ? "R6" : "R7") : "R11";
    else tag = "R13";
    if (o.trap) begin
      if (e_tl != MAXTL) begin
        m_pc[e_tl] = pc_i; m_npc[e_tl] = npc_i; m_tt[e_tl] = o.tt;
        m_st[e_tl] = {o.ccr, o.asi, 4'h0, o.pst & 12'hF3F, 5'b0, o.cwp};
        e_pc = {TBA, (e_tl > 1), o.tt, 5'b0};
        e_npc = e_pc + 64'd4;
        e_ccr = o.ccr; e_asi = o.asi;
        e_pst = 12'h015 | ((e_tl == MAXTL - 1) ? 12'h020 : 12'h000);
        if (o.tt == 9'h024) e_cwp = o.cwp - 3'd1;
        else if (o.tt[8:6] == 3'b010) e_cwp = o.cwp - o.cs - 3'd2;
        else if (o.tt[8:6] == 3'b011) e_cwp = o.cwp + 3'd1;
        else e_cwp = o.cwp;
        e_tl++; e_redir = 1;
      end else begin
        e_err = 1; e_redir = 0;
      end
    end else if (o.ret && e_tl > 0) begin
      e_pc  = o.retry ? m_pc[e_tl-1] : m_npc[e_tl-1];
      e_npc = o.retry ? m_npc[e_tl-1] : m_npc[e_tl-1] + 64'd4;
      e_ccr = m_st[e_tl-1][39:32]; e_asi = m_st[e_tl-1][31:24];
      e_pst = m_st[e_tl-1][19:8];  e_cwp = m_st[e_tl-1][2:0];
      e_tl--; e_redir = 1;
    end else e_redir = 0;
    chk(tag, "redirect", 64'(redirect_o), 64'(e_redir));
    chk(tag, "pc", pc_o, e_pc);
    chk(tag, "npc", npc_o, e_npc);
    chk(tag, "ccr", 64'(ccr_o), 64'(e_ccr));
    chk(tag, "asi", 64'(asi_o), 64'(e_asi));
    chk(o.ret && !o.trap ? "R8" : "R3", "pstate", 64'(pstate_o), 64'(e_pst));
    chk(o.ret && !o.trap ? "R8" : "R5", "cwp", 64'(cwp_o), 64'(e_cwp));
    chk(o.trap ? "R4" : "R8", "tl", 64'(tl_o), 64'(e_tl));
    chk("R9", "error", 64'(error_o), 64'(e_err));
    chk("R12", "top_tt", 64'(top_tt_o), (e_tl == 0) ? 64'd0 : 64'(m_tt[e_tl-1]));
    chk("R12", "top_state", 64'(top_state_o), (e_tl == 0) ? 64'd0 : 64'(m_st[e_tl-1]));
  endtask

  task automatic chk_reset();
    chk("R1", "tl", 64'(tl_o), 64'd0);
    chk("R1", "redirect", 64'(redirect_o), 64'd0);
    chk("R1", "error", 64'(error_o), 64'd0);
    chk("R1", "pc", pc_o, 64'd0);
    chk("R1", "npc", npc_o, 64'd0);
    chk("R1", "pstate", 64'(pstate_o), 64'd0);
    chk("R1", "top_tt", 64'(top_tt_o), 64'd0);
    chk("R1", "top_state", 64'(top_state_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk_reset();
    @(negedge clk) rst_ni = 1'b1;
    for (int i = 0; i < NOPS; i++) run_op(OPS[i]);
    // R9 error survives further traffic, cleared only by reset
    run_op('{1'b1,1'b0,1'b0,9'h041,32'h9000,8'h12,8'h34,12'h001,3'd0,3'd0});
    chk("R9", "error sticky", 64'(error_o), 64'd1);
    @(negedge clk) rst_ni = 1'b0;
    #1 chk_reset();
    e_tl = 0; e_err = 0; e_redir = 0; e_pc = 0; e_npc = 0;
    e_ccr = 0; e_asi = 0; e_pst = 0; e_cwp = 0;
    @(negedge clk) rst_ni = 1'b1;
    // R5 spill wraps below zero: 1 - 3 - 2 = -4 -> 4
    run_op('{1'b1,1'b0,1'b0,9'h0BF,32'hA000,8'h0F,8'hF0,12'hF3F,3'd1,3'd3});
    chk("R5", "spill wrap", 64'(cwp_o), 64'd4);
    chk("R2", "no nested bit at level 0", 64'(pc_o[14]), 64'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule